// File: doc/BRIEF.md
# Receiver Equalizer Adaptation Engine

This block tunes a receiver's equalization from sign-only observations taken once per recovered-clock cycle. Every cycle it receives the data slicer's bit decision, the edge slicer's sample taken halfway between the previous bit and the current one, and the sign of the error slicer. From these it maintains two sets of coefficients. The first is a 4-bit boost code for the continuous-time linear equalizer. The second is a set of five signed tap weights for the decision feedback equalizer.

The boost loop looks only at data transitions. On each transition the edge sample shows whether the waveform crossed late or early. If the edge sample matches the bit before it, the channel is under-equalized. If it matches the bit after it, the channel is over-equalized. These votes are summed over a programmable window. At the end of the window the code moves by at most one step, and only when the sum lies outside a deadband. The tap loop applies a sign-sign least-mean-square update to each weight at a programmable rate. Because tap 1 is used by a speculative slicer pair, its weight is also given out as a magnitude. A freeze input holds all adaptation. A load input seeds the coefficients.

Top module: `eq_adapt_engine`

## Requirements
- R1: A synchronous active-low reset sets the boost code to mid-scale (8) and every tap weight to zero.
- R2: Bit value 1 encodes +1 and 0 encodes -1. A boost vote is produced only when a previous decision exists and it differs from the current one. If the edge sample equals the previous decision, the vote is -1 (under-equalized, raise the boost). If it equals the current decision, the vote is +1 (over-equalized, lower the boost). A cycle without a transition produces no vote.
- R3: Votes are summed over windows of 2^win_sel_i votes. When the last vote of a window arrives, the code rises by one if the sum including that vote is below -deadband_i. It falls by one if the sum is above +deadband_i. Otherwise it stays. The sum and the window count then clear. No other event changes the code.
- R4: The boost code saturates at 0 and 15 and never wraps.
- R5: Once five decisions have been seen, every 2^upd_sel_i cycles each tap k (1..5) adds mu_i when the current error bit equals the decision from k cycles earlier, and subtracts mu_i otherwise. Tap k occupies bits [6(k-1)+5 : 6(k-1)] of taps_o.
- R6: Tap weights are 6-bit two's complement values that saturate at -32 and +31 and never wrap.
- R7: While freeze_i is high and load_i is low, the boost code, the tap weights, the vote sum, the window count and the update-rate count all hold. The decision history keeps shifting.
- R8: load_i takes priority over freeze_i and over adaptation. On the next cycle, boost and taps equal load_boost_i and load_taps_i, and the vote sum and both counts are cleared.
- R9: tap1_mag_o always equals the absolute value of tap 1 (0..32).
- R10: Driven by an error sign from a fixed intersymbol-interference channel, the tap weights settle within 3 of the channel's post-cursor coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_i | input | 1 | Data decision for this cycle (1 = +1) |
| edge_i | input | 1 | Edge sample between previous and current bit |
| err_i | input | 1 | Error slicer sign (1 = positive) |
| freeze_i | input | 1 | Hold all adaptation |
| load_i | input | 1 | Write seed coefficients |
| load_boost_i | input | 4 | Boost code to load |
| load_taps_i | input | 30 | Tap weights to load, packed as taps_o |
| win_sel_i | input | 4 | Vote window size exponent |
| deadband_i | input | 8 | Deadband on the window sum |
| mu_i | input | 3 | Tap step size |
| upd_sel_i | input | 4 | Tap update interval exponent |
| boost_o | output | 4 | Equalizer boost code |
| taps_o | output | 30 | Five signed tap weights |
| tap1_mag_o | output | 6 | Magnitude of tap 1 for the speculative slicers |

## Verification
Two events can meet in one cycle: a vote that closes a window or a tap-update tick can coincide with a load, and either can coincide with a freeze. A directed case uses a one-vote window so that every transition closes a window. Load is raised together with a transition, and the result must be the loaded code with no extra step. Freeze is raised together with a transition, and the code must hold. The random phase pulses freeze and load at random cycles with short windows and a short update interval. This makes these overlaps frequent, and the outputs are compared every cycle against a bench model built from the requirements.

// File: rtl/eq_adapt_pkg.sv
// Shared definitions for the equalizer adaptation engine.
// Assumes: decisions are coded 1 = +1, 0 = -1 throughout.
package eq_adapt_pkg;
    localparam int NTAPS_DEF   = 5;
    localparam int TAP_W_DEF   = 6;
    localparam int BOOST_W_DEF = 4;

    // Outcome of classifying one cycle for the boost loop.
    typedef enum logic [1:0] {
        VOTE_NONE  = 2'd0,
        VOTE_RAISE = 2'd1,
        VOTE_LOWER = 2'd2
    } vote_e;
endpackage

// File: rtl/eq_dec_history.sv
// Decision history: shift register of past data decisions plus a fill count.
// Assumes: one decision per clock; hist_o[0] is the previous cycle's bit.
module eq_dec_history #(
    parameter int DEPTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_i,
    output logic [DEPTH-1:0] hist_o,
    output logic             prev_ok_o,
    output logic             full_o
);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(DEPTH);

    logic [FILL_W-1:0] fill;

    // Shift in the newest decision and count how many are valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_o <= '0;
            fill   <= '0;
        end else begin
            hist_o <= {hist_o[DEPTH-2:0], dec_i};
            if (fill != FILL_MAX) fill <= fill + FILL_W'(1);
        end
    end

    assign prev_ok_o = (fill != '0);
    assign full_o    = (fill == FILL_MAX);
endmodule

// File: rtl/eq_boost_ctl.sv
// Boost loop: classifies transitions by the edge sample, integrates the votes
// over a window and steps a saturating boost code by one at window end.
// Assumes: load has priority over freeze; freeze holds sum and counters.
module eq_boost_ctl
    import eq_adapt_pkg::*;
#(
    parameter int BOOST_W   = 4,
    parameter int WIN_SEL_W = 4,
    parameter int DB_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prev_ok_i,
    input  logic                 prev_d_i,
    input  logic                 cur_d_i,
    input  logic                 edge_i,
    input  logic                 freeze_i,
    input  logic                 load_i,
    input  logic [BOOST_W-1:0]   load_boost_i,
    input  logic [WIN_SEL_W-1:0] win_sel_i,
    input  logic [DB_W-1:0]      deadband_i,
    output logic [BOOST_W-1:0]   boost_o
);
    localparam int CNT_W = (1 << WIN_SEL_W) + 1;
    localparam int ACC_W = (1 << WIN_SEL_W) + 2;
    localparam logic [BOOST_W-1:0] B_MAX = {BOOST_W{1'b1}};
    localparam logic [BOOST_W-1:0] B_MID = {1'b1, {(BOOST_W-1){1'b0}}};

    vote_e                    vote;
    logic [CNT_W-1:0]         cnt;
    logic [CNT_W-1:0]         win_last;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_nx;
    logic signed [ACC_W-1:0]  step;
    logic signed [ACC_W-1:0]  db_pos;
    logic signed [ACC_W-1:0]  db_neg;
    logic                     active;

    // Classify the current cycle from previous bit, edge sample and current bit.
    always_comb begin
        if (!prev_ok_i || (prev_d_i == cur_d_i)) vote = VOTE_NONE;
        else if (edge_i == prev_d_i)             vote = VOTE_RAISE;
        else                                     vote = VOTE_LOWER;
    end

    // Running sum including this cycle's vote and the deadband bounds.
    always_comb begin
        step     = (vote == VOTE_RAISE) ? {ACC_W{1'b1}} : ACC_W'(1);
        acc_nx   = acc + step;
        db_pos   = $signed({{(ACC_W-DB_W){1'b0}}, deadband_i});
        db_neg   = -db_pos;
        win_last = (CNT_W'(1) << win_sel_i) - CNT_W'(1);
        active   = (vote != VOTE_NONE) && !freeze_i;
    end

    // Integrate votes and apply at most one code step per completed window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boost_o <= B_MID;
            acc     <= '0;
            cnt     <= '0;
        end else if (load_i) begin
            boost_o <= load_boost_i;
            acc     <= '0;
            cnt     <= '0;
        end else if (active) begin
            if (cnt == win_last) begin
                acc <= '0;
                cnt <= '0;
                if ((acc_nx < db_neg) && (boost_o != B_MAX))
                    boost_o <= boost_o + BOOST_W'(1);
                else if ((acc_nx > db_pos) && (boost_o != '0))
                    boost_o <= boost_o - BOOST_W'(1);
            end else begin
                acc <= acc_nx;
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/eq_tap_lms.sv
// Feedback tap loop: sign-sign LMS on saturating signed weights, applied
// once every 2^upd_sel_i cycles after the decision history is full.
// Assumes: hist_i[k] holds the decision k+1 cycles back.
module eq_tap_lms #(
    parameter int NTAPS     = 5,
    parameter int TAP_W     = 6,
    parameter int MU_W      = 3,
    parameter int UPD_SEL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NTAPS-1:0]       hist_i,
    input  logic                   full_i,
    input  logic                   err_i,
    input  logic                   freeze_i,
    input  logic                   load_i,
    input  logic [NTAPS*TAP_W-1:0] load_taps_i,
    input  logic [MU_W-1:0]        mu_i,
    input  logic [UPD_SEL_W-1:0]   upd_sel_i,
    output logic [NTAPS*TAP_W-1:0] taps_o
);
    localparam int UC_W  = (1 << UPD_SEL_W) + 1;
    localparam int SUM_W = ((TAP_W > MU_W) ? TAP_W : MU_W) + 2;
    localparam logic signed [SUM_W-1:0] W_MAX = SUM_W'((1 << (TAP_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] W_MIN = -SUM_W'(1 << (TAP_W - 1));

    logic [UC_W-1:0] uc;
    logic [UC_W-1:0] uc_last;
    logic            tick;
    logic            upd_en;

    // Rate divider: a tick at the last count of each interval.
    always_comb begin
        uc_last = (UC_W'(1) << upd_sel_i) - UC_W'(1);
        tick    = !freeze_i && !load_i && (uc == uc_last);
        upd_en  = tick && full_i;
    end

    // Interval counter; cleared by load and held by freeze.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)  uc <= '0;
        else if (freeze_i)     uc <= uc;
        else if (uc == uc_last) uc <= '0;
        else                   uc <= uc + UC_W'(1);
    end

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        logic signed [TAP_W-1:0] w;
        logic signed [SUM_W-1:0] w_ext;
        logic signed [SUM_W-1:0] stp;
        logic signed [SUM_W-1:0] sum;
        logic signed [SUM_W-1:0] sat;

        // Candidate weight: step toward agreement of error and past decision.
        always_comb begin
            w_ext = {{(SUM_W-TAP_W){w[TAP_W-1]}}, w};
            stp   = $signed({{(SUM_W-MU_W){1'b0}}, mu_i});
            sum   = (err_i == hist_i[k]) ? (w_ext + stp) : (w_ext - stp);
            if (sum > W_MAX)      sat = W_MAX;
            else if (sum < W_MIN) sat = W_MIN;
            else                  sat = sum;
        end

        // Weight register with load priority and gated update.
        always_ff @(posedge clk) begin
            if (!rst_n)      w <= '0;
            else if (load_i) w <= load_taps_i[k*TAP_W +: TAP_W];
            else if (upd_en) w <= sat[TAP_W-1:0];
        end

        assign taps_o[k*TAP_W +: TAP_W] = w;
    end
endmodule

// File: rtl/eq_adapt_engine.sv
// Top of the equalizer adaptation engine: decision history, boost loop,
// feedback tap loop and the tap-1 magnitude for the speculative slicers.
// Assumes: one decision, edge sample and error sign per recovered clock.
module eq_adapt_engine #(
    parameter int NTAPS     = eq_adapt_pkg::NTAPS_DEF,
    parameter int TAP_W     = eq_adapt_pkg::TAP_W_DEF,
    parameter int BOOST_W   = eq_adapt_pkg::BOOST_W_DEF,
    parameter int WIN_SEL_W = 4,
    parameter int DB_W      = 8,
    parameter int MU_W      = 3,
    parameter int UPD_SEL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dec_i,
    input  logic                   edge_i,
    input  logic                   err_i,
    input  logic                   freeze_i,
    input  logic                   load_i,
    input  logic [BOOST_W-1:0]     load_boost_i,
    input  logic [NTAPS*TAP_W-1:0] load_taps_i,
    input  logic [WIN_SEL_W-1:0]   win_sel_i,
    input  logic [DB_W-1:0]        deadband_i,
    input  logic [MU_W-1:0]        mu_i,
    input  logic [UPD_SEL_W-1:0]   upd_sel_i,
    output logic [BOOST_W-1:0]     boost_o,
    output logic [NTAPS*TAP_W-1:0] taps_o,
    output logic [TAP_W-1:0]       tap1_mag_o
);
    logic [NTAPS-1:0] hist;
    logic             prev_ok;
    logic             full;
    logic [TAP_W-1:0] w1;

    eq_dec_history #(.DEPTH(NTAPS)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_i     (dec_i),
        .hist_o    (hist),
        .prev_ok_o (prev_ok),
        .full_o    (full)
    );

    eq_boost_ctl #(
        .BOOST_W   (BOOST_W),
        .WIN_SEL_W (WIN_SEL_W),
        .DB_W      (DB_W)
    ) u_boost (
        .clk          (clk),
        .rst_n        (rst_n),
        .prev_ok_i    (prev_ok),
        .prev_d_i     (hist[0]),
        .cur_d_i      (dec_i),
        .edge_i       (edge_i),
        .freeze_i     (freeze_i),
        .load_i       (load_i),
        .load_boost_i (load_boost_i),
        .win_sel_i    (win_sel_i),
        .deadband_i   (deadband_i),
        .boost_o      (boost_o)
    );

    eq_tap_lms #(
        .NTAPS     (NTAPS),
        .TAP_W     (TAP_W),
        .MU_W      (MU_W),
        .UPD_SEL_W (UPD_SEL_W)
    ) u_taps (
        .clk         (clk),
        .rst_n       (rst_n),
        .hist_i      (hist),
        .full_i      (full),
        .err_i       (err_i),
        .freeze_i    (freeze_i),
        .load_i      (load_i),
        .load_taps_i (load_taps_i),
        .mu_i        (mu_i),
        .upd_sel_i   (upd_sel_i),
        .taps_o      (taps_o)
    );

    // Absolute value of tap 1; the most negative weight maps to 2^(TAP_W-1).
    always_comb begin
        w1         = taps_o[TAP_W-1:0];
        tap1_mag_o = w1[TAP_W-1] ? (~w1 + TAP_W'(1)) : w1;
    end
endmodule

// File: rtl/eq_adapt_engine_chk.sv
// Property checker for the adaptation engine, attached by bind below.
// Assumes: reset is synchronous and active low.
module eq_adapt_engine_chk #(
    parameter int NTAPS   = 5,
    parameter int TAP_W   = 6,
    parameter int BOOST_W = 4,
    parameter int MU_W    = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   freeze_i,
    input logic                   load_i,
    input logic [BOOST_W-1:0]     load_boost_i,
    input logic [NTAPS*TAP_W-1:0] load_taps_i,
    input logic [BOOST_W-1:0]     boost_o,
    input logic [NTAPS*TAP_W-1:0] taps_o
);
    localparam int MU_MAX = (1 << MU_W) - 1;
    localparam logic [BOOST_W-1:0] B_MID = {1'b1, {(BOOST_W-1){1'b0}}};

    // Reset leaves mid-scale boost and cleared taps (R1).
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (boost_o == B_MID && taps_o == '0));

    // Outside of load the code moves by at most one per cycle (R3).
    assert_boost_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((int'(boost_o) - int'($past(boost_o)) <= 1) &&
                     (int'($past(boost_o)) - int'(boost_o) <= 1)));

    // Tap 1 moves by no more than the largest step outside of load (R5).
    assert_tap_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ((int'($signed(taps_o[TAP_W-1:0])) -
                      int'($signed($past(taps_o[TAP_W-1:0])))) <= MU_MAX &&
                     (int'($signed($past(taps_o[TAP_W-1:0]))) -
                      int'($signed(taps_o[TAP_W-1:0]))) <= MU_MAX));

    // Freeze without load holds every coefficient (R7).
    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !load_i) |=> ($stable(boost_o) && $stable(taps_o)));

    // Load writes the seed values on the next cycle (R8).
    assert_load_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (boost_o == $past(load_boost_i) && taps_o == $past(load_taps_i)));
endmodule

bind eq_adapt_engine eq_adapt_engine_chk #(
    .NTAPS   (NTAPS),
    .TAP_W   (TAP_W),
    .BOOST_W (BOOST_W),
    .MU_W    (MU_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .freeze_i     (freeze_i),
    .load_i       (load_i),
    .load_boost_i (load_boost_i),
    .load_taps_i  (load_taps_i),
    .boost_o      (boost_o),
    .taps_o       (taps_o)
);

// File: tb/eq_adapt_engine_bench.sv
`timescale 1ns/1ps
module eq_adapt_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_i = 1'b0, edge_i = 1'b0, err_i = 1'b0;
    logic        freeze_i = 1'b0, load_i = 1'b0;
    logic [3:0]  load_boost_i = '0;
    logic [29:0] load_taps_i = '0;
    logic [3:0]  win_sel_i = '0;
    logic [7:0]  deadband_i = '0;
    logic [2:0]  mu_i = 3'd1;
    logic [3:0]  upd_sel_i = '0;
    logic [3:0]  boost_o;
    logic [29:0] taps_o;
    logic [5:0]  tap1_mag_o;

    int checks = 0, fails = 0;
    int m_boost, m_acc, m_cnt, m_uc, m_fill;
    int m_taps[5];
    bit m_hist[5];
    int h_ch[5] = '{9, -6, 4, -3, 2};

    eq_adapt_engine u_eq_adapt_engine (
        .clk(clk), .rst_n(rst_n), .dec_i(dec_i), .edge_i(edge_i), .err_i(err_i),
        .freeze_i(freeze_i), .load_i(load_i), .load_boost_i(load_boost_i),
        .load_taps_i(load_taps_i), .win_sel_i(win_sel_i), .deadband_i(deadband_i),
        .mu_i(mu_i), .upd_sel_i(upd_sel_i), .boost_o(boost_o), .taps_o(taps_o),
        .tap1_mag_o(tap1_mag_o)
    );

    always #2.5 clk = ~clk;

    function automatic int sat(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic int tap_of(logic [29:0] v, int k);
        logic signed [5:0] t = v[k*6 +: 6];
        return int'(t);
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_boost = 8; m_acc = 0; m_cnt = 0; m_uc = 0; m_fill = 0;
        for (int k = 0; k < 5; k++) begin m_taps[k] = 0; m_hist[k] = 1'b0; end
    endtask

    // Bench model of one clock, written from the requirements.
    task automatic model_step(bit d, bit ed, bit er, bit frz, bit ld, int lb, logic [29:0] lt);
        int v, s;
        if (ld) begin
            m_boost = lb; m_acc = 0; m_cnt = 0; m_uc = 0;
            for (int k = 0; k < 5; k++) m_taps[k] = tap_of(lt, k);
        end else if (!frz) begin
            if (m_fill >= 1 && m_hist[0] != d) begin
                v = (ed == m_hist[0]) ? -1 : 1;
                if (m_cnt == (1 << int'(win_sel_i)) - 1) begin
                    s = m_acc + v;
                    if (s < -int'(deadband_i))     m_boost = sat(m_boost + 1, 0, 15);
                    else if (s > int'(deadband_i)) m_boost = sat(m_boost - 1, 0, 15);
                    m_acc = 0; m_cnt = 0;
                end else begin
                    m_acc += v; m_cnt++;
                end
            end
            if (m_uc == (1 << int'(upd_sel_i)) - 1) begin
                m_uc = 0;
                if (m_fill >= 5)
                    for (int k = 0; k < 5; k++)
                        m_taps[k] = sat(m_taps[k] + ((er == m_hist[k]) ? int'(mu_i) : -int'(mu_i)), -32, 31);
            end else m_uc++;
        end
        for (int k = 4; k > 0; k--) m_hist[k] = m_hist[k-1];
        m_hist[0] = d;
        if (m_fill < 5) m_fill++;
    endtask

    task automatic compare_all(string req);
        chk(req, int'(boost_o), m_boost, "boost");
        for (int k = 0; k < 5; k++) chk(req, tap_of(taps_o, k), m_taps[k], "tap");
        chk("R9", int'(tap1_mag_o), iabs(m_taps[0]), "tap1 magnitude");
    endtask

    task automatic step(bit d, bit ed, bit er, bit frz, bit ld, int lb, logic [29:0] lt, string req);
        @(negedge clk);
        dec_i = d; edge_i = ed; err_i = er; freeze_i = frz; load_i = ld;
        load_boost_i = 4'(lb); load_taps_i = lt;
        @(posedge clk);
        model_step(d, ed, er, frz, ld, lb, lt);
        #1;
        compare_all(req);
    endtask

    // Transition whose edge sample sides with the previous (raise) or current bit.
    task automatic trans(bit raise, string req);
        bit d = ~m_hist[0];
        step(d, raise ? m_hist[0] : d, 1'b0, 1'b0, 1'b0, 0, '0, req);
    endtask

    function automatic logic [29:0] pack_all(int v);
        logic [29:0] r;
        for (int k = 0; k < 5; k++) r[k*6 +: 6] = 6'(v);
        return r;
    endfunction

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed, s, er, b0;
        logic [29:0] lt;
        seed = 7;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #0.1;
        // R1: reset state seen at the ports.
        chk("R1", int'(boost_o), 8, "boost after reset");
        chk("R1", int'(taps_o), 0, "taps after reset");

        // R2/R3: under-equalized transitions raise by one after a 4-vote window.
        win_sel_i = 4'd2; deadband_i = 8'd0; mu_i = 3'd0; upd_sel_i = 4'd0;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, '0, "R2");
        for (int i = 0; i < 4; i++) trans(1'b1, "R2");
        chk("R2", int'(boost_o), 9, "raise after under votes");
        // R2: no transitions give no votes.
        for (int i = 0; i < 12; i++) step(m_hist[0], ~m_hist[0], 1'b0, 1'b0, 1'b0, 0, '0, "R2");
        chk("R2", int'(boost_o), 9, "no change without transitions");
        // R2/R3: over-equalized transitions lower.
        for (int i = 0; i < 8; i++) trans(1'b0, "R3");
        chk("R3", int'(boost_o), 7, "lower after over votes");
        // R3: sum of +2 does not pass deadband 2.
        deadband_i = 8'd2;
        trans(1'b0, "R3"); trans(1'b0, "R3"); trans(1'b0, "R3"); trans(1'b1, "R3");
        chk("R3", int'(boost_o), 7, "sum inside deadband");
        trans(1'b0, "R3"); trans(1'b0, "R3"); trans(1'b0, "R3"); trans(1'b0, "R3");
        chk("R3", int'(boost_o), 6, "sum beyond deadband");

        // R4: saturation at both ends with a one-vote window.
        win_sel_i = 4'd0; deadband_i = 8'd0;
        for (int i = 0; i < 20; i++) trans(1'b1, "R4");
        chk("R4", int'(boost_o), 15, "saturate high");
        for (int i = 0; i < 20; i++) trans(1'b0, "R4");
        chk("R4", int'(boost_o), 0, "saturate low");

        // R8: load coincides with a window-closing transition; load wins.
        step(~m_hist[0], m_hist[0], 1'b0, 1'b0, 1'b1, 5, pack_all(3), "R8");
        chk("R8", int'(boost_o), 5, "load beats window end");
        // R7: freeze coincides with a window-closing transition; code holds.
        for (int i = 0; i < 6; i++) step(~m_hist[0], m_hist[0], 1'b1, 1'b1, 1'b0, 0, '0, "R7");
        chk("R7", int'(boost_o), 5, "freeze holds boost");
        chk("R7", tap_of(taps_o, 2), 3, "freeze holds tap");
        // R8: load while frozen still writes.
        step(m_hist[0], 1'b0, 1'b0, 1'b1, 1'b1, 12, pack_all(-4), "R8");
        chk("R8", tap_of(taps_o, 4), -4, "load beats freeze");

        // R5/R6: constant data with agreeing error drives taps to +31.
        mu_i = 3'd7; upd_sel_i = 4'd0;
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8, pack_all(28), "R6");
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0, '0, "R6");
        chk("R6", tap_of(taps_o, 0), 31, "saturate at +31");
        for (int i = 0; i < 14; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, '0, "R6");
        chk("R6", tap_of(taps_o, 3), -32, "saturate at -32");
        chk("R9", int'(tap1_mag_o), 32, "magnitude of -32");
        // R5: update every 4 cycles with step 2.
        mu_i = 3'd2; upd_sel_i = 4'd2;
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8, '0, "R5");
        b0 = 0;
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0, '0, "R5");
        chk("R5", tap_of(taps_o, 0), 4, "two updates in eight cycles");

        // Random mix: R3/R5/R7/R8 overlaps, compared every cycle.
        win_sel_i = 4'd1; deadband_i = 8'd0; upd_sel_i = 4'd1;
        for (int i = 0; i < 3000; i++) begin
            mu_i = 3'($urandom_range(0, 7));
            for (int k = 0; k < 5; k++) lt[k*6 +: 6] = 6'($urandom);
            step(1'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 7) == 0), ($urandom_range(0, 39) == 0),
                 int'($urandom_range(0, 15)), lt, "R5");
        end

        // R10: convergence toward the bench channel's post-cursor taps.
        mu_i = 3'd1; upd_sel_i = 4'd0;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8, '0, "R10");
        for (int i = 0; i < 4000; i++) begin
            s = 0;
            for (int k = 0; k < 5; k++) s += (h_ch[k] - m_taps[k]) * (m_hist[k] ? 1 : -1);
            er = (s >= 0);
            step(1'($urandom), 1'($urandom), 1'(er), 1'b0, 1'b0, 0, '0, "R10");
        end
        for (int k = 0; k < 5; k++) begin
            checks++;
            if (iabs(tap_of(taps_o, k) - h_ch[k]) > 3) begin
                fails++;
                $display("FAIL R10 tap%0d: actual=%0d expected=%0d+-3", k + 1, tap_of(taps_o, k), h_ch[k]);
            end
        end

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule